// File: doc/BRIEF.md
# Level/Edge Interrupt Pending Tracker

This block keeps the pending state of a bank of 32 private interrupt lines. Each line is either level-sensitive or edge-triggered. A rising input on an edge-triggered line sets a sticky pending bit. A level-sensitive line is seen as pending for exactly as long as its input stays high. Software can also set or clear the sticky bits. An acknowledge strobe from the interrupt consumer clears one bit.

The block produces two views. The effective pending vector is the sticky bits merged with the live level of the level-sensitive lines; priority logic reads it directly. A software-facing view applies the group visibility mask to that vector.

The trigger mode of each line is reached through a 32-bit configuration word that uses two bits per line. The edge flag of a line sits in the odd bit of its field. Word 0 covers lines 0..15 and is read-only. Word 1 covers lines 16..31 and is writable, within the limits of the group mask.

Top module: `irq_pend_track`

## Requirements
- R1: When a line's input equals the level stored for it at the previous clock, nothing happens. An edge line held high after its bit was cleared does not set that bit again.
- R2: When a line configured as edge-triggered goes from low to high, its sticky pending bit is set at the next clock edge.
- R3: `pend_eff` equals sticky | (line_lvl & ~edge_cfg). The level term is combinational, so a level-sensitive line shows pending in the same cycle its input is high, and not in the cycle it is low.
- R4: A falling input never clears a sticky bit. Only a software clear or an acknowledge clears it.
- R5: `sw_set` ORs `sw_data & grp_mask` into the sticky bits, and `sw_clr` removes `sw_data & grp_mask`. When a set, or an edge, and a clear hit the same bit in one cycle, the clear wins.
- R6: `ack_vld` clears the sticky bit numbered `ack_id` at the next clock edge.
- R7: `cfg_rdata` with `cfg_sel`=0 returns the edge flag of line n (0..15), ANDed with `grp_mask[n]`, at bit 2n+1. Writes with `cfg_sel`=0 change nothing.
- R8: `cfg_rdata` with `cfg_sel`=1 returns `edge_cfg[16+n] & grp_mask[16+n]` at bit 2n+1. All even bits of `cfg_rdata` read as zero.
- R9: A write with `cfg_sel`=1 loads `edge_cfg[16+n]` from `cfg_wdata[2n+1]`, but only where `grp_mask[16+n]` is 1. Even bits of the write data are ignored.
- R10: After reset all sticky bits are 0, `edge_cfg` is 32'h0000FFFF (lines 0..15 edge-triggered, lines 16..31 level-sensitive), and every stored level is 0.
- R11: `pend_view` equals `pend_eff & grp_mask`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_lvl | input | 32 | Current level of each interrupt line |
| grp_mask | input | 32 | Group visibility mask for software access |
| sw_set | input | 1 | Software set strobe for sticky bits |
| sw_clr | input | 1 | Software clear strobe for sticky bits |
| sw_data | input | 32 | Bit vector for set/clear |
| ack_vld | input | 1 | Acknowledge strobe |
| ack_id | input | 5 | Line cleared by acknowledge |
| cfg_wr | input | 1 | Configuration word write strobe |
| cfg_sel | input | 1 | Configuration word select (0: lines 0..15, 1: lines 16..31) |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Packed configuration read data for `cfg_sel` |
| edge_cfg | output | 32 | Edge-trigger flag per line |
| pend_eff | output | 32 | Effective pending vector |
| pend_view | output | 32 | Effective pending masked by `grp_mask` |

## Verification
The checker assumes that `grp_mask` holds steady across a configuration write. It also assumes that strobes are single-cycle levels sampled only at the clock edge. The bench changes the mask only between transactions and drives every strobe for exactly one cycle. The sticky-bit checks assume that no clear or acknowledge is present in the cycle being examined. The bench therefore separates edge events from clears, except in the one scenario that exercises a clear colliding with a set. Inputs are held low through reset, so no edge appears at the first clock after reset.

// File: rtl/irq_pend_pkg.sv
package irq_pend_pkg;
  localparam int NLINES = 32;
  localparam int HALF   = NLINES / 2;
  localparam int IDW    = $clog2(NLINES);
  localparam int CFGW   = 2 * HALF;
  localparam logic [NLINES-1:0] EDGE_RST = {{HALF{1'b0}}, {HALF{1'b1}}};

  function automatic logic [CFGW-1:0] cfg_pack(input logic [HALF-1:0] flags);
    logic [CFGW-1:0] w;
    w = '0;
    for (int n = 0; n < HALF; n++) w[2*n+1] = flags[n];
    return w;
  endfunction

  function automatic logic [HALF-1:0] cfg_unpack(input logic [CFGW-1:0] w);
    logic [HALF-1:0] f;
    for (int n = 0; n < HALF; n++) f[n] = w[2*n+1];
    return f;
  endfunction
endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] line_lvl,
  input  logic [N-1:0] edge_cfg,
  output logic [N-1:0] edge_rise
);
  logic [N-1:0] lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= '0;
    else        lvl_q <= line_lvl;
  end

  // only a change against the stored level counts; edge lines only
  assign edge_rise = line_lvl & ~lvl_q & edge_cfg;
endmodule

// File: rtl/irq_pend_latch.sv
module irq_pend_latch #(
  parameter int N   = 32,
  parameter int IDW = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   edge_rise,
  input  logic [N-1:0]   grp_mask,
  input  logic           sw_set,
  input  logic           sw_clr,
  input  logic [N-1:0]   sw_data,
  input  logic           ack_vld,
  input  logic [IDW-1:0] ack_id,
  output logic [N-1:0]   latch_q
);
  logic [N-1:0] set_vec, clr_vec, ack_vec;

  always_comb begin
    ack_vec = '0;
    if (ack_vld) ack_vec[ack_id] = 1'b1;
  end

  assign set_vec = edge_rise | ({N{sw_set}} & sw_data & grp_mask);
  assign clr_vec = ack_vec   | ({N{sw_clr}} & sw_data & grp_mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) latch_q <= '0;
    else        latch_q <= (latch_q | set_vec) & ~clr_vec;
  end
endmodule

// File: rtl/irq_cfg_port.sv
module irq_cfg_port
  import irq_pend_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] grp_mask,
  input  logic              cfg_wr,
  input  logic              cfg_sel,
  input  logic [CFGW-1:0]   cfg_wdata,
  output logic [CFGW-1:0]   cfg_rdata,
  output logic [NLINES-1:0] edge_cfg
);
  logic [HALF-1:0] hi_q;
  logic [HALF-1:0] hi_new, hi_msk;

  assign hi_new = cfg_unpack(cfg_wdata);
  assign hi_msk = grp_mask[NLINES-1:HALF];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      hi_q <= EDGE_RST[NLINES-1:HALF];
    else if (cfg_wr && cfg_sel)
      hi_q <= (hi_q & ~hi_msk) | (hi_new & hi_msk);
  end

  // lower half is fixed at its reset value; writes to it are dropped
  assign edge_cfg = {hi_q, EDGE_RST[HALF-1:0]};

  assign cfg_rdata = cfg_sel ? cfg_pack(hi_q & hi_msk)
                             : cfg_pack(EDGE_RST[HALF-1:0] & grp_mask[HALF-1:0]);
endmodule

// File: rtl/irq_pend_track.sv
module irq_pend_track
  import irq_pend_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] line_lvl,
  input  logic [NLINES-1:0] grp_mask,
  input  logic              sw_set,
  input  logic              sw_clr,
  input  logic [NLINES-1:0] sw_data,
  input  logic              ack_vld,
  input  logic [IDW-1:0]    ack_id,
  input  logic              cfg_wr,
  input  logic              cfg_sel,
  input  logic [CFGW-1:0]   cfg_wdata,
  output logic [CFGW-1:0]   cfg_rdata,
  output logic [NLINES-1:0] edge_cfg,
  output logic [NLINES-1:0] pend_eff,
  output logic [NLINES-1:0] pend_view
);
  logic [NLINES-1:0] edge_rise;
  logic [NLINES-1:0] latch_q;

  irq_cfg_port u_cfg (
    .clk(clk), .rst_n(rst_n), .grp_mask(grp_mask),
    .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .edge_cfg(edge_cfg)
  );

  irq_edge_det #(.N(NLINES)) u_edge (
    .clk(clk), .rst_n(rst_n), .line_lvl(line_lvl),
    .edge_cfg(edge_cfg), .edge_rise(edge_rise)
  );

  irq_pend_latch #(.N(NLINES), .IDW(IDW)) u_latch (
    .clk(clk), .rst_n(rst_n), .edge_rise(edge_rise), .grp_mask(grp_mask),
    .sw_set(sw_set), .sw_clr(sw_clr), .sw_data(sw_data),
    .ack_vld(ack_vld), .ack_id(ack_id), .latch_q(latch_q)
  );

  assign pend_eff  = latch_q | (line_lvl & ~edge_cfg);
  assign pend_view = pend_eff & grp_mask;
endmodule

// File: rtl/irq_pend_track_chk.sv
module irq_pend_track_chk
  import irq_pend_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [NLINES-1:0] line_lvl,
  input logic [NLINES-1:0] grp_mask,
  input logic              sw_clr,
  input logic              ack_vld,
  input logic              cfg_wr,
  input logic              cfg_sel,
  input logic [CFGW-1:0]   cfg_rdata,
  input logic [NLINES-1:0] edge_cfg,
  input logic [NLINES-1:0] pend_eff,
  input logic [NLINES-1:0] edge_rise,
  input logic [NLINES-1:0] latch_q
);
  AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_rise != '0 && !sw_clr && !ack_vld) |=>
      ((latch_q & $past(edge_rise)) == $past(edge_rise))); // R2

  AST_NO_SILENT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_clr && !ack_vld) |=> (($past(latch_q) & ~latch_q) == '0)); // R4

  AST_LEVEL_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    ((line_lvl & ~edge_cfg & ~pend_eff) == '0)); // R3

  AST_EVEN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ((cfg_rdata & {HALF{2'b01}}) == '0)); // R8

  AST_LOW_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> $stable(edge_cfg[HALF-1:0])); // R7

  AST_MASKED_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_sel) |=> (((edge_cfg ^ $past(edge_cfg)) & ~$past(grp_mask)) == '0)); // R9
endmodule

bind irq_pend_track irq_pend_track_chk i_chk (
  .clk(clk), .rst_n(rst_n), .line_lvl(line_lvl), .grp_mask(grp_mask),
  .sw_clr(sw_clr), .ack_vld(ack_vld), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
  .cfg_rdata(cfg_rdata), .edge_cfg(edge_cfg), .pend_eff(pend_eff),
  .edge_rise(edge_rise), .latch_q(latch_q)
);

// File: tb/test_irq_pend_track.sv
module test_irq_pend_track;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] line_lvl = '0, grp_mask = '1, sw_data = '0, cfg_wdata = '0;
  logic        sw_set = 1'b0, sw_clr = 1'b0, ack_vld = 1'b0, cfg_wr = 1'b0, cfg_sel = 1'b0;
  logic [4:0]  ack_id = '0;
  logic [31:0] cfg_rdata, edge_cfg, pend_eff, pend_view;
  int errors = 0, checks = 0;

  always #4 clk = ~clk;

  irq_pend_track i_irq_pend_track (
    .clk(clk), .rst_n(rst_n), .line_lvl(line_lvl), .grp_mask(grp_mask),
    .sw_set(sw_set), .sw_clr(sw_clr), .sw_data(sw_data),
    .ack_vld(ack_vld), .ack_id(ack_id), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .edge_cfg(edge_cfg),
    .pend_eff(pend_eff), .pend_view(pend_view)
  );

  function automatic logic [31:0] pack_ref(input logic [15:0] f);
    logic [31:0] w = '0;
    for (int i = 0; i < 16; i++) if (f[i]) w = w | (32'd2 << (2 * i));
    return w;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic clear_all();
    grp_mask = '1; sw_data = '1; sw_clr = 1'b1; tick(); sw_clr = 1'b0; sw_data = '0;
  endtask

  task automatic t_reset();
    check("R10 pend", pend_eff, 32'h0);
    check("R10 edge_cfg", edge_cfg, 32'h0000FFFF);
    cfg_sel = 1'b0; #1 check("R7 read low", cfg_rdata, 32'hAAAAAAAA);
    cfg_sel = 1'b1; #1 check("R8 read high", cfg_rdata, 32'h0);
  endtask

  task automatic t_edge();
    line_lvl[3] = 1'b1; tick();
    check("R2 edge sets", pend_eff, 32'h8);
    sw_data = 32'h8; sw_clr = 1'b1; tick(); sw_clr = 1'b0; sw_data = '0;
    check("R5 clear", pend_eff, 32'h0);
    tick(); tick();
    check("R1 held high no re-set", pend_eff, 32'h0);
    line_lvl[3] = 1'b0; line_lvl[5] = 1'b1; tick();
    line_lvl[5] = 1'b0; tick(); tick();
    check("R4 fall keeps latch", pend_eff, 32'h20);
    clear_all();
  endtask

  task automatic t_level();
    line_lvl[20] = 1'b1; #1
    check("R3 level live", pend_eff, 32'h0010_0000);
    tick();
    line_lvl[20] = 1'b0; #1
    check("R3 level gone", pend_eff, 32'h0);
    grp_mask = 32'h0000_00FF; line_lvl[20] = 1'b1; line_lvl[2] = 1'b1; tick(); #1
    check("R11 view masked", pend_view, 32'h4);
    line_lvl = '0; clear_all();
  endtask

  task automatic t_sw();
    grp_mask = 32'h0000_FF00; sw_data = 32'h0000_FFFF; sw_set = 1'b1; tick(); sw_set = 1'b0;
    check("R5 masked set", pend_eff, 32'h0000_FF00);
    sw_data = 32'h0000_0300; sw_set = 1'b1; sw_clr = 1'b1; tick(); sw_set = 1'b0; sw_clr = 1'b0;
    check("R5 clear wins", pend_eff, 32'h0000_FC00);
    grp_mask = 32'h0000_00FF; sw_data = 32'h0000_FFFF; sw_clr = 1'b1; tick(); sw_clr = 1'b0;
    check("R5 masked clear", pend_eff, 32'h0000_FC00);
    clear_all();
  endtask

  task automatic t_ack();
    sw_data = 32'h6; sw_set = 1'b1; tick(); sw_set = 1'b0;
    ack_id = 5'd2; ack_vld = 1'b1; tick(); ack_vld = 1'b0;
    check("R6 ack clears one", pend_eff, 32'h2);
    clear_all();
  endtask

  task automatic t_cfg();
    grp_mask = '1; cfg_sel = 1'b1; cfg_wdata = 32'h8000_0003; cfg_wr = 1'b1; tick(); cfg_wr = 1'b0;
    check("R9 write high", edge_cfg, 32'h8001_FFFF);
    #1 check("R8 pack high", cfg_rdata, pack_ref(16'h8001));
    grp_mask = 32'hFFFE_FFFF; cfg_wdata = 32'h0; cfg_wr = 1'b1; tick(); cfg_wr = 1'b0;
    check("R9 mask protects", edge_cfg, 32'h0001_FFFF);
    #1 check("R8 read masked", cfg_rdata, 32'h0);
    cfg_sel = 1'b0; cfg_wdata = 32'h0; cfg_wr = 1'b1; tick(); cfg_wr = 1'b0;
    check("R7 low write ignored", edge_cfg, 32'h0001_FFFF);
    grp_mask = 32'h0000_00F0; #1
    check("R7 read low masked", cfg_rdata, pack_ref(16'h00F0));
    grp_mask = '1; line_lvl[16] = 1'b1; tick(); line_lvl[16] = 1'b0; tick();
    check("R2 reconfigured edge", pend_eff, 32'h0001_0000);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1; @(negedge clk);
        t_reset(); t_edge(); t_level(); t_sw(); t_ack(); t_cfg();
      end
      begin
        repeat (5000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule